// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This peripheral keeps time as an unsigned count of whole seconds. A prescaler divides the input clock down to one update tick per second. On each tick the visible count goes up by one. Software reaches the block through a simple register bus with an address, write and read strobes, write data and read data. Through that bus it can start and stop time, preset the count, and set an alarm value.

A value written to the preset register is held back and copied into the visible count at the next update tick. That tick takes the place of the increment for that second. When an update produces a count equal to the alarm value, a sticky raw event bit is set. An enable bit and a mask bit decide whether that event reaches the interrupt output. Software clears the event by reading an acknowledge register. Writing to that register has no effect.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register reads 0 and `alarm_irq` is low.
- R2: While control bit 2 (run) is 1, the current count at offset 0x00 changes once every TICKS_PER_SEC clock cycles. While run is 0, both the count and the prescaler phase hold their values.
- R3: A write to offset 0x08 (preset) leaves the count unchanged until the next update tick. At that tick the count takes the preset value exactly, with no increment added. Reading 0x08 returns the last preset written.
- R4: At the all-ones count, an update tick keeps the count at all-ones when control bit 3 (wrap) is 0. When wrap is 1, the tick sets the count to zero.
- R5: When an update tick produces a count equal to the alarm register at offset 0x04, raw status bit 0 at offset 0x14 becomes 1. This happens whatever the states of the enable and mask bits.
- R6: `alarm_irq` and bit 0 of offset 0x10 both equal raw AND control bit 0 (enable) AND NOT control bit 1 (mask).
- R7: A read of offset 0x18 returns the raw bit and clears it. If a new match occurs in the same cycle, the raw bit stays set.
- R8: Writes to offsets 0x00, 0x10, 0x14 and 0x18 change nothing. A read of an unmapped offset returns 0. Control occupies bits 3:0 of offset 0x0C.
- R9: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to the prescaler and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| alarm_irq | output | 1 | Alarm interrupt, active high |

## Verification
The bench builds the block with TICKS_PER_SEC set to 5. At that setting a second lasts five clocks, so dozens of update ticks, preset hand-overs and alarm matches fit in a short run. The bench can then steer a read of the acknowledge register onto the exact clock of a tick. Presetting the count near all-ones brings both the saturating and the rolling end of the 32-bit range within a few ticks. The counter width stays at its full 32 bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CTL_IE   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_RUN  = 2;
  localparam int CTL_WRAP = 3;
  localparam int CTL_W    = 4;

  localparam logic [7:0] OFF_NOW   = 8'h00;
  localparam logic [7:0] OFF_MATCH = 8'h04;
  localparam logic [7:0] OFF_LOAD  = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_RAW   = 8'h14;
  localparam logic [7:0] OFF_ACK   = 8'h18;

  // next count on a plain update tick
  function automatic logic [31:0] sec_advance(input logic [31:0] cur, input logic wrap);
    if (&cur) return wrap ? 32'd0 : cur;
    return cur + 32'd1;
  endfunction

  // interrupt level from raw event and control bits
  function automatic logic irq_gate(input logic raw, input logic [CTL_W-1:0] ctl);
    return raw & ctl[CTL_IE] & ~ctl[CTL_MASK];
  endfunction
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  generate
    if (TICKS_PER_SEC == 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] phase_q;
      assign tick = run && (phase_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      phase_q <= '0;
        else if (tick)   phase_q <= '0;
        else if (run)    phase_q <= phase_q + 1'b1;
      end

      // R2
      hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase_q));
    end
  endgenerate
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrap,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] sec_o,
  output logic [CNT_W-1:0] load_o,
  output logic             match_evt
);
  import rtc_pkg::*;

  logic [CNT_W-1:0] sec_q, load_q, sec_nxt;
  logic             pend_q;

  assign sec_nxt   = pend_q ? load_q : CNT_W'(sec_advance(32'(sec_q), wrap));
  assign match_evt = tick && (sec_nxt == match_val);
  assign sec_o     = sec_q;
  assign load_o    = load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      load_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick) sec_q <= sec_nxt;
      if (load_wr) begin
        load_q <= load_data;
        pend_q <= 1'b1;
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sec_q));
  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_q) |=> (sec_q == $past(load_q)));
  // R4
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && !wrap && (&sec_q)) |=> (&sec_q));
  // R4
  roll_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q && wrap && (&sec_q)) |=> (sec_q == '0));
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              alarm_irq
);
  import rtc_pkg::*;

  logic [CTL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0] match_q, rdata_q, sec_now, load_now;
  logic              raw_q, tick, match_evt, ack_rd, load_wr, irq_lvl;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  assign load_wr = bus_wr && at(bus_addr, OFF_LOAD);
  assign ack_rd  = bus_rd && at(bus_addr, OFF_ACK);
  assign irq_lvl = irq_gate(raw_q, ctrl_q);

  rtc_prescale #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTL_RUN]), .tick(tick));

  rtc_seconds #(.CNT_W(DATA_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(ctrl_q[CTL_WRAP]),
    .load_wr(load_wr), .load_data(bus_wdata), .match_val(match_q),
    .sec_o(sec_now), .load_o(load_now), .match_evt(match_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
      raw_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && at(bus_addr, OFF_CTRL))  ctrl_q  <= bus_wdata[CTL_W-1:0];
      if (bus_wr && at(bus_addr, OFF_MATCH)) match_q <= bus_wdata;
      if (match_evt)   raw_q <= 1'b1;
      else if (ack_rd) raw_q <= 1'b0;
      if (bus_rd) begin
        if      (at(bus_addr, OFF_NOW))   rdata_q <= sec_now;
        else if (at(bus_addr, OFF_MATCH)) rdata_q <= match_q;
        else if (at(bus_addr, OFF_LOAD))  rdata_q <= load_now;
        else if (at(bus_addr, OFF_CTRL))  rdata_q <= DATA_W'(ctrl_q);
        else if (at(bus_addr, OFF_STAT))  rdata_q <= DATA_W'(irq_lvl);
        else if (at(bus_addr, OFF_RAW))   rdata_q <= DATA_W'(raw_q);
        else if (at(bus_addr, OFF_ACK))   rdata_q <= DATA_W'(raw_q);
        else                              rdata_q <= '0;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign alarm_irq = irq_lvl;

  // R5
  match_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> raw_q);
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !match_evt) |=> !raw_q);
  // R6
  irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> raw_q);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  localparam int T = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        alarm_irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string rtag = "R9";

  // reference model state
  int unsigned m_psc = 0;
  logic [31:0] m_sec = 0, m_ld = 0, m_match = 0, m_rexp = 0;
  logic [3:0]  m_ctl = 0;
  logic        m_pend = 0, m_raw = 0;

  always #2 clk = ~clk;

  sec_rtc #(.TICKS_PER_SEC(T), .ADDR_W(8), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] model_next();
    if (m_pend) return m_ld;
    if (m_sec == 32'hFFFF_FFFF) return m_ctl[3] ? 32'd0 : m_sec;
    return m_sec + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psc = 0; m_sec = 0; m_ld = 0; m_match = 0; m_ctl = 0;
      m_pend = 0; m_raw = 0; m_rexp = 0;
    end else begin
      logic tk, ev;
      logic [31:0] nv;
      tk = m_ctl[2] && (m_psc == T - 1);
      nv = model_next();
      ev = tk && (nv == m_match);
      if (bus_rd) begin
        case (bus_addr)
          8'h00: m_rexp = m_sec;
          8'h04: m_rexp = m_match;
          8'h08: m_rexp = m_ld;
          8'h0C: m_rexp = {28'd0, m_ctl};
          8'h10: m_rexp = {31'd0, m_raw & m_ctl[0] & ~m_ctl[1]};
          8'h14: m_rexp = {31'd0, m_raw};
          8'h18: m_rexp = {31'd0, m_raw};
          default: m_rexp = 0;
        endcase
      end
      if (m_ctl[2]) m_psc = tk ? 0 : m_psc + 1;
      if (tk) begin m_sec = nv; m_pend = 0; end
      if (ev) m_raw = 1;
      else if (bus_rd && bus_addr == 8'h18) m_raw = 0;
      if (bus_wr) begin
        case (bus_addr)
          8'h04: m_match = bus_wdata;
          8'h08: begin m_ld = bus_wdata; m_pend = 1; end
          8'h0C: m_ctl = bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R6 irq", {31'd0, alarm_irq}, {31'd0, m_raw & m_ctl[0] & ~m_ctl[1]});
      check({rtag, " rdata"}, bus_rdata, m_rexp);
    end
    if (cycles > 200000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<200000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    rtag = tag; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    for (int k = 0; k < 8; k++) begin
      rd(8'(k * 4), "R1", v);
      check("R1 reset value", v, 32'd0);
    end
    check("R1 irq after reset", {31'd0, alarm_irq}, 32'd0);

    // R2 counting and holding
    wr(8'h0C, 32'h4);
    idle(3 * T + 2);
    rd(8'h00, "R2", v);
    wr(8'h0C, 32'h0);
    rd(8'h00, "R2", v);
    idle(4 * T);
    rd(8'h00, "R2", v2);
    check("R2 hold while stopped", v2, v);

    // R3 preset hand-over
    wr(8'h08, 32'd100);
    rd(8'h08, "R3", v);
    check("R3 preset readback", v, 32'd100);
    rd(8'h00, "R3", v);
    check("R3 not visible before tick", v, v2);
    wr(8'h0C, 32'h4);
    idle(T + 1);
    rd(8'h00, "R3", v);
    check("R3 preset taken exactly", v, 32'd100);

    // R5 and R6: match with enable
    wr(8'h04, 32'd103);
    wr(8'h0C, 32'h5);
    idle(4 * T);
    rd(8'h14, "R5", v);
    check("R5 raw set on match", v, 32'd1);
    check("R6 irq on", {31'd0, alarm_irq}, 32'd1);
    rd(8'h18, "R7", v);
    check("R7 ack returns raw", v, 32'd1);
    idle(1);
    check("R7 irq cleared", {31'd0, alarm_irq}, 32'd0);

    // R5 with mask: raw sets, output stays low
    wr(8'h0C, 32'h7);
    wr(8'h04, m_sec + 2);
    idle(3 * T);
    rd(8'h14, "R5", v);
    check("R5 raw set while masked", v, 32'd1);
    rd(8'h10, "R6", v);
    check("R6 masked status low", v, 32'd0);
    wr(8'h0C, 32'h5);
    idle(1);
    check("R6 irq after unmask", {31'd0, alarm_irq}, 32'd1);

    // R7 ack in the same cycle as a fresh match
    wr(8'h04, m_sec + 2);
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (m_psc == T - 1 && model_next() == m_match) break;
    end
    bus_addr = 8'h18; bus_rd = 1'b1; rtag = "R7";
    @(negedge clk);
    bus_rd = 1'b0;
    check("R7 ack during match returns raw", bus_rdata, 32'd1);
    rd(8'h14, "R7", v);
    check("R7 raw kept by new match", v, 32'd1);
    rd(8'h18, "R7", v);

    // R4 saturate then roll
    wr(8'h0C, 32'h4);
    wr(8'h08, 32'hFFFF_FFFE);
    idle(4 * T);
    rd(8'h00, "R4", v);
    check("R4 saturates at all-ones", v, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hC);
    idle(2 * T);
    rd(8'h00, "R4", v);
    check("R4 rolled below 3", {31'd0, v < 32'd3}, 32'd1);

    // R8 read-only and unmapped offsets
    wr(8'h0C, 32'h0);
    rd(8'h00, "R8", v);
    wr(8'h00, 32'h1234_5678);
    wr(8'h14, 32'h1);
    wr(8'h10, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h00, "R8", v2);
    check("R8 count untouched", v2, v);
    rd(8'h14, "R8", v);
    check("R8 raw untouched", v, 32'd0);
    rd(8'h1C, "R8", v);
    check("R8 unmapped reads zero", v, 32'd0);
    wr(8'h0C, 32'hFFFF_FFFA);
    rd(8'h0C, "R8", v);
    check("R8 control width", v, 32'hA);

    // R9 read data holds between reads
    idle(5);
    check("R9 rdata held", bus_rdata, 32'hA);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule